// File: doc/BRIEF.md
# Atomic Swap Lock Memory

A small word-addressed memory shared by several requesters behind one bus. Each requester raises a request with an operation code, an address and a write word. A round-robin arbiter hands the bus to one requester at a time. The block supports three kinds of access: a plain load, a plain store, and an indivisible swap. The swap returns the word that was stored and writes the requester's new word to the same location. The bus stays with the swapping requester from the read until the write, so no other access can land in between.

The intended use is a spin lock. A word holding 0 is free and a word holding 1 is taken. A requester acquires the lock by swapping in a 1. Only a returned 0 means it has won. Any other requester racing for the same lock gets back the 1 that the winner wrote, and its own write of 1 leaves the word as it was. The owner frees the lock with a plain store of 0.

Each requester keeps its request raised until it sees its grant. The block captures the operation, address and write word when it issues the grant, so the requester can drop or change them in the next cycle.

Top module: `swap_lock_mem`

## Requirements
- R1: At most one grant bit is high in any cycle. A grant is issued only to a requester whose request was high in the cycle before the grant.
- R2: Arbitration is round-robin. When the bus is free, the grant goes to the first requesting index found by searching cyclically upward from the index after the last requester that was granted. After reset the search starts at index 0.
- R3: A load holds the grant for one cycle. In the next cycle the block raises a single-cycle valid pulse only on the owner's bit and places the addressed word on the read data output.
- R4: A store holds the grant for one cycle and writes the word to the addressed location. It raises no read-valid pulse.
- R5: A swap holds the grant for two consecutive cycles. During the second cycle the old word is returned with a valid pulse to the owner, and at the end of that cycle the new word is stored.
- R6: Requesters racing to acquire the same lock by swapping in 1 are serialised. Exactly one of them receives 0, every other one receives 1, and the lock word ends at 1.
- R7: After reset, every memory word reads 0, and all grant and read-valid bits are low.
- R8: Operation encoding: 2'b00 is a load, 2'b01 is a store, 2'b10 is a swap, and 2'b11 behaves as a load that leaves memory unchanged.
- R9: A store of 0 releases a lock. The next acquiring swap on that word returns 0, and a swap after that returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_REQ | Request, one bit per requester |
| op | input | 2*N_REQ | Operation code per requester, requester i in bits [2i+1:2i] |
| addr | input | ADDR_W*N_REQ | Word address per requester |
| wdata | input | DATA_W*N_REQ | Write word per requester |
| gnt | output | N_REQ | One-hot bus grant |
| rvalid | output | N_REQ | Single-cycle read-valid pulse to the owner |
| rdata | output | DATA_W | Read word or old word returned by a swap |

## Verification
The hardest case to reach is several requesters asking for the same lock word in the same cycle. That is the only way to show that no second access slips between a swap's read and its write, and that the losers see the winner's 1 rather than the original 0. The bench starts independent per-requester tasks in parallel from one clock edge, so all of them raise their requests together. It then counts the returned values and records the grant order. A separate step first grants a single requester alone. This moves the round-robin pointer away from its reset position before a three-way race, so the cyclic search has to wrap around past the last index.

// File: rtl/srl_pkg.sv
package srl_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_SWAP  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACCESS = 2'b01,
    ST_SWAPWR = 2'b10
  } bus_st_e;
endpackage

// File: rtl/srl_rr_arb.sv
module srl_rr_arb #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             adv,
  output logic             any,
  output logic [IDX_W-1:0] pick
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      int c;
      c = (int'(last_q) + k) % N_REQ;
      if (!any && req[c]) begin
        any  = 1'b1;
        pick = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IDX_W'(N_REQ - 1);
    end else if (adv) begin
      last_q <= pick;
    end
  end
endmodule

// File: rtl/srl_mem.sv
module srl_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words_q [DEPTH];

  assign rdata = words_q[addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[g] <= '0;
      end else if (hit) begin
        words_q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/swap_lock_mem.sv
module swap_lock_mem
  import srl_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req,
  input  logic [2*N_REQ-1:0]      op,
  input  logic [ADDR_W*N_REQ-1:0] addr,
  input  logic [DATA_W*N_REQ-1:0] wdata,
  output logic [N_REQ-1:0]        gnt,
  output logic [N_REQ-1:0]        rvalid,
  output logic [DATA_W-1:0]       rdata
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  bus_st_e           state_q, state_d;
  logic [IDX_W-1:0]  owner_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [N_REQ-1:0]  rvalid_q;

  logic              arb_any;
  logic [IDX_W-1:0]  arb_pick;
  logic              cap_en;
  logic              rd_en;
  logic              mem_we;
  logic              swap_rd;
  logic [DATA_W-1:0] mem_rdata;
  logic [N_REQ-1:0]  owner_oh;

  assign cap_en = (state_q == ST_IDLE) && arb_any;

  srl_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .adv  (cap_en),
    .any  (arb_any),
    .pick (arb_pick)
  );

  srl_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .addr (addr_q),
    .wdata(wdata_q),
    .rdata(mem_rdata)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (arb_any) state_d = ST_ACCESS;
      ST_ACCESS: state_d = (op_q == OP_SWAP) ? ST_SWAPWR : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign swap_rd  = (state_q == ST_ACCESS) && (op_q == OP_SWAP);
  assign rd_en    = (state_q == ST_ACCESS) && (op_q != OP_STORE);
  assign mem_we   = ((state_q == ST_ACCESS) && (op_q == OP_STORE)) ||
                    (state_q == ST_SWAPWR);
  assign owner_oh = N_REQ'(1) << owner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      owner_q <= arb_pick;
      op_q    <= op_e'(op[2*arb_pick +: 2]);
      addr_q  <= addr[ADDR_W*arb_pick +: ADDR_W];
      wdata_q <= wdata[DATA_W*arb_pick +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= '0;
    end else begin
      rvalid_q <= rd_en ? owner_oh : '0;
    end
  end

  assign gnt    = (state_q != ST_IDLE) ? owner_oh : '0;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req,
  input logic [N_REQ-1:0] gnt,
  input logic [N_REQ-1:0] rvalid,
  input logic             swap_rd,
  input logic             mem_we
);
  a_r1_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r1_gnt_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~$past(gnt)) != '0) |-> ((gnt & $past(req)) == gnt));

  a_r3_rvalid_to_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid != '0) |-> (($countones(rvalid) == 1) && ((rvalid & $past(gnt)) == rvalid)));

  a_r5_swap_holds_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    swap_rd |=> ((gnt == $past(gnt)) && mem_we && (rvalid == gnt)));

  a_r6_no_handover: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && ($past(gnt) != '0)) |-> (gnt == $past(gnt)));
endmodule

bind swap_lock_mem srl_checker #(.N_REQ(N_REQ)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (req),
  .gnt    (gnt),
  .rvalid (rvalid),
  .swap_rd(swap_rd),
  .mem_we (mem_we)
);

// File: tb/tb_swap_lock_mem.sv
module tb_swap_lock_mem;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 8;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req;
  logic [2*N-1:0]  op;
  logic [AW*N-1:0] addr;
  logic [DW*N-1:0] wdata;
  logic [N-1:0]    gnt;
  logic [N-1:0]    rvalid;
  logic [DW-1:0]   rdata;

  int n_chk;
  int n_fail;
  int order_log [16];
  int n_log;
  bit done;

  swap_lock_mem #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr),
    .wdata(wdata), .gnt(gnt), .rvalid(rvalid), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rq(input int i, input logic [1:0] o, input logic [AW-1:0] a,
                    input logic [DW-1:0] w, output logic [DW-1:0] d);
    @(negedge clk);
    req[i] = 1'b1;
    op[2*i +: 2] = o;
    addr[AW*i +: AW] = a;
    wdata[DW*i +: DW] = w;
    do @(negedge clk); while (!gnt[i]);
    order_log[n_log % 16] = i;
    n_log++;
    req[i] = 1'b0;
    @(negedge clk);
    d = '0;
    if (o == 2'b01) begin
      chk(rvalid[i] == 1'b0, "R4 store gives no read-valid", int'(rvalid[i]), 0);
    end else begin
      chk(rvalid[i] == 1'b1, "R3 read-valid pulse to owner", int'(rvalid[i]), 1);
      d = rdata;
    end
    if (o == 2'b10) begin
      chk(gnt[i] == 1'b1, "R5 grant held in swap write cycle", int'(gnt[i]), 1);
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk(gnt == '0, "R7 grant low after reset", int'(gnt), 0);
    chk(rvalid == '0, "R7 read-valid low after reset", int'(rvalid), 0);
    rq(0, 2'b00, 4'd5, 8'h00, d);
    chk(d == 8'h00, "R7 memory zero after reset", int'(d), 0);
  endtask

  task automatic t_store_load();
    logic [DW-1:0] d;
    rq(2, 2'b01, 4'd6, 8'hA5, d);
    rq(0, 2'b00, 4'd6, 8'h00, d);
    chk(d == 8'hA5, "R4 stored word read back (R3 load)", int'(d), 'hA5);
  endtask

  task automatic t_rsvd_op();
    logic [DW-1:0] d;
    rq(1, 2'b11, 4'd6, 8'h11, d);
    chk(d == 8'hA5, "R8 code 11 acts as load", int'(d), 'hA5);
    rq(3, 2'b00, 4'd6, 8'h00, d);
    chk(d == 8'hA5, "R8 code 11 leaves memory unchanged", int'(d), 'hA5);
  endtask

  task automatic t_swap();
    logic [DW-1:0] d;
    rq(3, 2'b10, 4'd6, 8'h3C, d);
    chk(d == 8'hA5, "R5 swap returns old word", int'(d), 'hA5);
    rq(2, 2'b00, 4'd6, 8'h00, d);
    chk(d == 8'h3C, "R5 swap stores new word", int'(d), 'h3C);
  endtask

  task automatic t_round_robin();
    logic [DW-1:0] d0, d1, d3;
    rq(1, 2'b00, 4'd0, 8'h00, d1);
    n_log = 0;
    fork
      rq(0, 2'b00, 4'd0, 8'h00, d0);
      rq(1, 2'b00, 4'd0, 8'h00, d1);
      rq(3, 2'b00, 4'd0, 8'h00, d3);
    join
    chk(n_log == 3, "R2 three grants issued", n_log, 3);
    chk(order_log[0] == 3, "R2 first grant after last owner 1", order_log[0], 3);
    chk(order_log[1] == 0, "R2 search wraps to index 0", order_log[1], 0);
    chk(order_log[2] == 1, "R2 index 1 served last", order_log[2], 1);
  endtask

  task automatic t_race();
    logic [DW-1:0] r0, r1, r2, r3, d;
    int zeros;
    int ones;
    fork
      rq(0, 2'b10, 4'd2, 8'h01, r0);
      rq(1, 2'b10, 4'd2, 8'h01, r1);
      rq(2, 2'b10, 4'd2, 8'h01, r2);
      rq(3, 2'b10, 4'd2, 8'h01, r3);
    join
    zeros = int'(r0 == 0) + int'(r1 == 0) + int'(r2 == 0) + int'(r3 == 0);
    ones  = int'(r0 == 1) + int'(r1 == 1) + int'(r2 == 1) + int'(r3 == 1);
    chk(zeros == 1, "R6 exactly one racer sees unlocked", zeros, 1);
    chk(ones == 3, "R6 losers see locked", ones, 3);
    rq(0, 2'b00, 4'd2, 8'h00, d);
    chk(d == 8'h01, "R6 lock word stays 1", int'(d), 1);
  endtask

  task automatic t_release();
    logic [DW-1:0] d;
    rq(2, 2'b01, 4'd2, 8'h00, d);
    rq(1, 2'b10, 4'd2, 8'h01, d);
    chk(d == 8'h00, "R9 acquire after release wins", int'(d), 0);
    rq(0, 2'b10, 4'd2, 8'h01, d);
    chk(d == 8'h01, "R9 second acquire loses", int'(d), 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    n_log = 0;
    done = 1'b0;
    req = '0;
    op = '0;
    addr = '0;
    wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_load();
    t_rsvd_op();
    t_swap();
    t_round_robin();
    t_race();
    t_release();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule